// File: doc/BRIEF.md
# Write-Enable Latch and Status Register Guard

This unit sits beside the command decoder of a serial byte memory. It keeps the one-bit write-enable latch and the few stored bits of the status register. The decoder hands it single-cycle strobes: arm writes, disarm writes, load the status register with a byte, and a completed memory write. The unit returns the status byte that a status read shifts out, and a flag that says whether a memory write may go ahead.

The latch can only be changed by the arm and disarm commands and by completed writes. A status-register load never writes the latch. Any accepted write clears it again. The active-low protect pin blocks status-register loads only. Memory writes still depend on the latch alone.

The decoder raises the completion strobe when chip select rises after at least one data byte of a permitted write. The unit itself knows nothing about serial framing.

Top module: `wel_status_guard`

## Requirements
- R1: After reset is released, `statusByte` reads 0x00 and `writeAllowed` reads 0.
- R2: An `armWrites` pulse, with no clearing event in the same cycle, sets the latch. From the next cycle `writeAllowed` is 1 and `statusByte` bit 1 is 1.
- R3: A `disarmWrites` pulse clears the latch, so `writeAllowed` and `statusByte` bit 1 read 0 on the next cycle.
- R4: A `memWriteDone` pulse while the latch is 1 clears the latch on the next cycle.
- R5: A `statusWrite` pulse is accepted when the latch is 1 and `wpN` is 1. On the next cycle, `statusByte` bits 7, 3 and 2 hold the matching bits of `statusData`, and the latch is 0.
- R6: `statusByte` bits 0, 4, 5 and 6 always read 0. A status load never sets the latch, whatever value bit 1 of `statusData` carries.
- R7: While `wpN` is 0, a `statusWrite` pulse is refused. The stored status bits are unchanged and the latch keeps its value.
- R8: While the latch is 0, a `statusWrite` pulse is refused and the stored status bits are unchanged. A `memWriteDone` pulse while the latch is 0 has no effect either.
- R9: When a clearing event occurs in the same cycle as `armWrites`, the latch ends at 0. The clearing events are `disarmWrites`, an accepted status load and an accepted memory completion.
- R10: `wpN` at 0 does not affect `writeAllowed`, and it does not affect the clearing of the latch by an accepted memory completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armWrites | input | 1 | Decoded strobe that sets the write-enable latch |
| disarmWrites | input | 1 | Decoded strobe that clears the latch |
| statusWrite | input | 1 | Decoded strobe that asks to load the status register |
| statusData | input | 8 | Byte offered with `statusWrite` |
| memWriteDone | input | 1 | A memory write has completed |
| wpN | input | 1 | Active-low write-protect pin, guards the status register only |
| statusByte | output | 8 | Status byte for reads, latch at bit 1 |
| writeAllowed | output | 1 | Latch state, which gates memory writes |

## Verification
Arming can fall in the same cycle as a clearing event. The clearing event is either an accepted memory completion or an accepted status load. The bench first arms the latch. It then pulses `armWrites` together with `memWriteDone`, and in a second case together with `statusWrite`. It expects the latch to read 0 on the next cycle, and in the second case it also expects the new status bits to be stored. A further case pulses the disarm and arm strobes together and expects 0.

// File: rtl/wel_guard_pkg.sv
package wel_guard_pkg;
  typedef struct packed {
    logic latchSet;
    logic latchClr;
    logic statusLoad;
  } guardStrb_t;
endpackage

// File: rtl/wel_guard_ctrl.sv
module wel_guard_ctrl
  import wel_guard_pkg::*;
(
  input  logic       armWrites,
  input  logic       disarmWrites,
  input  logic       statusWrite,
  input  logic       memWriteDone,
  input  logic       wpN,
  input  logic       latchQ,
  output guardStrb_t strb
);
  logic statusOk;
  logic memOk;

  always_comb begin
    statusOk        = statusWrite & latchQ & wpN;
    memOk           = memWriteDone & latchQ;
    strb.statusLoad = statusOk;
    strb.latchSet   = armWrites;
    strb.latchClr   = disarmWrites | statusOk | memOk;
  end
endmodule

// File: rtl/wel_guard_dp.sv
module wel_guard_dp
  import wel_guard_pkg::*;
#(
  parameter int          WIDTH    = 8,
  parameter int          WEL_BIT  = 1,
  parameter logic [7:0]  KEEP_MASK = 8'b1000_1100
) (
  input  logic             clk,
  input  logic             rstN,
  input  guardStrb_t       strb,
  input  logic [WIDTH-1:0] dataIn,
  output logic             latchQ,
  output logic [WIDTH-1:0] statusOut
);
  localparam logic [WIDTH-1:0] StoreMask = KEEP_MASK[WIDTH-1:0] & ~(WIDTH'(1) << WEL_BIT);

  logic [WIDTH-1:0] keptBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
    end else if (strb.latchClr) begin
      latchQ <= 1'b0;
    end else if (strb.latchSet) begin
      latchQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keptBits <= '0;
    end else if (strb.statusLoad) begin
      keptBits <= dataIn & StoreMask;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    if (i == WEL_BIT) begin : gWel
      assign statusOut[i] = latchQ;
    end else if (StoreMask[i]) begin : gKeep
      assign statusOut[i] = keptBits[i];
    end else begin : gZero
      assign statusOut[i] = 1'b0;
    end
  end

  // R6
  kept_bits_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keptBits & ~StoreMask) == '0);
  // R5
  load_takes_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.statusLoad |=> keptBits == ($past(dataIn) & StoreMask));
endmodule

// File: rtl/wel_status_guard.sv
module wel_status_guard
  import wel_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armWrites,
  input  logic       disarmWrites,
  input  logic       statusWrite,
  input  logic [7:0] statusData,
  input  logic       memWriteDone,
  input  logic       wpN,
  output logic [7:0] statusByte,
  output logic       writeAllowed
);
  guardStrb_t strb;
  logic       latchQ;

  wel_guard_ctrl u_ctrl (
    .armWrites    (armWrites),
    .disarmWrites (disarmWrites),
    .statusWrite  (statusWrite),
    .memWriteDone (memWriteDone),
    .wpN          (wpN),
    .latchQ       (latchQ),
    .strb         (strb)
  );

  wel_guard_dp #(.WIDTH(8), .WEL_BIT(1), .KEEP_MASK(8'b1000_1100)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dataIn    (statusData),
    .latchQ    (latchQ),
    .statusOut (statusByte)
  );

  assign writeAllowed = latchQ;

  // R2
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armWrites && !disarmWrites && !memWriteDone && !statusWrite) |=> writeAllowed);
  // R3
  disarm_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    disarmWrites |=> !writeAllowed);
  // R9
  mem_done_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWriteDone && writeAllowed) |=> !writeAllowed);
  // R7
  wp_blocks_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wpN && statusWrite && !armWrites && !disarmWrites && !memWriteDone) |=> $stable(statusByte));
  // R6
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte & 8'b0111_0001) == 8'h00);
endmodule

// File: tb/wel_status_guard_bench.sv
module wel_status_guard_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       armWrites = 1'b0, disarmWrites = 1'b0, statusWrite = 1'b0, memWriteDone = 1'b0;
  logic [7:0] statusData = 8'h00;
  logic       wpN = 1'b1;
  logic [7:0] statusByte;
  logic       writeAllowed;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  wel_status_guard u_wel_status_guard (
    .clk(clk), .rstN(rstN), .armWrites(armWrites), .disarmWrites(disarmWrites),
    .statusWrite(statusWrite), .statusData(statusData), .memWriteDone(memWriteDone),
    .wpN(wpN), .statusByte(statusByte), .writeAllowed(writeAllowed)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one-cycle strobe; outputs sampled at the following falling edge
  task automatic cycle(input logic a, input logic d, input logic sw, input logic [7:0] dat,
                       input logic md);
    @(negedge clk);
    armWrites = a; disarmWrites = d; statusWrite = sw; statusData = dat; memWriteDone = md;
    @(negedge clk);
    armWrites = 0; disarmWrites = 0; statusWrite = 0; memWriteDone = 0;
  endtask

  task automatic tReset();
    rstN = 0; wpN = 1;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 status", statusByte, 8'h00);
    check("R1 allowed", {7'b0, writeAllowed}, 8'h01 & 8'h00);
  endtask

  task automatic tArm();
    cycle(1, 0, 0, 8'h00, 0);
    check("R2 allowed", {7'b0, writeAllowed}, 8'h01);
    check("R2 status", statusByte, 8'h02);
  endtask

  task automatic tDisarm();
    cycle(1, 0, 0, 8'h00, 0);
    cycle(0, 1, 0, 8'h00, 0);
    check("R3 status", statusByte, 8'h00);
  endtask

  task automatic tMemDone();
    cycle(1, 0, 0, 8'h00, 0);
    cycle(0, 0, 0, 8'h00, 1);
    check("R4 allowed", {7'b0, writeAllowed}, 8'h00);
  endtask

  task automatic tStatusLoad();
    cycle(1, 0, 0, 8'h00, 0);
    cycle(0, 0, 1, 8'hFF, 0);
    check("R5 R6 status", statusByte, 8'h8C);
    cycle(1, 0, 0, 8'h00, 0);
    cycle(0, 0, 1, 8'h06, 0);
    check("R5 status 06", statusByte, 8'h04);
  endtask

  task automatic tWpBlock();
    cycle(1, 0, 0, 8'h00, 0);
    wpN = 0;
    cycle(0, 0, 1, 8'h88, 0);
    check("R7 status", statusByte, 8'h06);
    check("R10 allowed wp low", {7'b0, writeAllowed}, 8'h01);
    cycle(0, 0, 0, 8'h00, 1);
    check("R10 mem done wp low", {7'b0, writeAllowed}, 8'h00);
    wpN = 1;
  endtask

  task automatic tNoLatch();
    cycle(0, 0, 1, 8'h80, 0);
    check("R8 status", statusByte, 8'h04);
    cycle(0, 0, 0, 8'h00, 1);
    check("R8 mem done", statusByte, 8'h04);
  endtask

  task automatic tCollide();
    cycle(1, 0, 0, 8'h00, 0);
    cycle(1, 0, 0, 8'h00, 1);
    check("R9 arm+memdone", statusByte, 8'h04);
    cycle(1, 0, 0, 8'h00, 0);
    cycle(1, 0, 1, 8'h08, 0);
    check("R9 arm+status", statusByte, 8'h08);
    cycle(1, 1, 0, 8'h00, 0);
    check("R9 arm+disarm", statusByte, 8'h08);
  endtask

  initial begin
    tReset();
    tArm();
    tDisarm();
    tMemDone();
    tStatusLoad();
    tWpBlock();
    tNoLatch();
    tCollide();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule